// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Set/Clear Registers

This block controls 32 general-purpose pins split into two banks of 16. Each bank holds eight per-pin feature registers: output level, output enable, open-drain, output inversion, pull-up, pull-down, input enable and input inversion. It also has a read-only register that returns the sampled input levels. The pad outputs are decoded from these registers, and the pad inputs are synchronised before software can read them.

Every write to a feature register uses a set/clear format. A 1 in the lower half of the data word sets that pin's bit. A 1 in the upper half clears it. Software can change one pin with a single write, with no read-modify-write and no race against other code that changes other pins. The second bank uses the same register layout as the first, placed 0x80 above it.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, every feature register is 0. Every pad is undriven (`pad_oe` = 0), the pull outputs are 0, and `rdata` is 0.
- R2: The address is a byte address. Bit 7 selects the bank: 0 is pins 0..15 and 1 is pins 16..31. Pin n of a bank is bit n of that bank's registers. Word offsets are 0x00 output level, 0x04 output enable, 0x08 open-drain, 0x0C output invert, 0x18 pull-up, 0x1C pull-down, 0x20 input enable, 0x24 input invert and 0x30 read-back.
- R3: A write to a feature register sets every bit k for which `wdata[k]` is 1 (k < 16). Bits named by neither half keep their value.
- R4: A write clears every bit k for which `wdata[k+16]` is 1. When both the set bit and the clear bit of a pin are 1 in one write, the bit ends at 0.
- R5: A read is requested by `rd_en` and appears on `rdata` after the next clock edge. It holds there until the next read. A feature register read returns its state in [15:0] and the bitwise inverse of that state in [31:16].
- R6: `pad_out` equals output level XOR output invert. When open-drain is clear, `pad_oe` equals the output enable bit.
- R7: When open-drain is set, the pad is driven only if output enable is set and `pad_out` is 0.
- R8: `pad_pu` and `pad_pd` follow the pull-up and pull-down registers of each pin directly.
- R9: Read-back bits [15:0] equal the pad input after two synchronising flops, XOR input invert, for pins whose input enable is set. All other bits read 0. A pad change made before edge A is not seen by a read captured at edge A+1, and is seen by a read captured at edge A+2.
- R10: Writes to read-back, to offsets not listed in R2, or to addresses with bits [1:0] non-zero change no state. Reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address: bank in bit 7, offset in [6:0] |
| wdata | input | 32 | Write data: set mask in [15:0], clear mask in [31:16] |
| rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Pad output level |
| pad_oe | output | 32 | Pad output enable |
| pad_pu | output | 32 | Pad pull-up enable |
| pad_pd | output | 32 | Pad pull-down enable |

## Verification
The assertions assume that `wr_en`, `rd_en`, `addr` and `wdata` are stable around each rising edge. They also assume that `pad_in` has a known value from reset onward, because the synchroniser check compares its output with the input two cycles back. The stimulus changes every input only on the falling clock edge and holds `pad_in` at a defined value from time zero. It never raises `wr_en` and `rd_en` in the same cycle, so each expected read value is computed against a settled register state.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

  localparam int NFEAT = 8;
  localparam int OFF_W = 7;

  typedef enum logic [2:0] {
    F_OUTV = 3'd0,
    F_OE   = 3'd1,
    F_OD   = 3'd2,
    F_OINV = 3'd3,
    F_PU   = 3'd4,
    F_PD   = 3'd5,
    F_IE   = 3'd6,
    F_IINV = 3'd7
  } feat_e;

  typedef struct packed {
    logic  hit;
    logic  is_rb;
    feat_e feat;
  } dec_t;

  function automatic dec_t decode_off(input logic [OFF_W-1:0] off);
    dec_t d;
    d.hit   = 1'b1;
    d.is_rb = 1'b0;
    d.feat  = F_OUTV;
    case (off)
      7'h00:   d.feat = F_OUTV;
      7'h04:   d.feat = F_OE;
      7'h08:   d.feat = F_OD;
      7'h0C:   d.feat = F_OINV;
      7'h18:   d.feat = F_PU;
      7'h1C:   d.feat = F_PD;
      7'h20:   d.feat = F_IE;
      7'h24:   d.feat = F_IINV;
      7'h30:   d.is_rb = 1'b1;
      default: d.hit = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gpio_sc_reg.sv
module gpio_sc_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic [W-1:0] q_r;

  always_comb begin
    q_d = q_r;
    if (we) q_d = (q_r | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (we) q_r <= q_d;
  end

  assign q = q_r;

  a_r3_set_applies: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q & $past(set_mask & ~clr_mask)) == $past(set_mask & ~clr_mask)));

  a_r3_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q & ~$past(set_mask | clr_mask)) == ($past(q) & ~$past(set_mask | clr_mask))));

  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q & $past(clr_mask)) == '0));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

  a_r9_two_flop_delay: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n, 1)) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_sc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NFEAT-1:0]           wr_sel,
  input  logic [2*W-1:0]             wdata,
  input  logic [W-1:0]               pad_in,
  output logic [NFEAT-1:0][W-1:0]    feat_q,
  output logic [W-1:0]               rb_val,
  output logic [W-1:0]               pad_out,
  output logic [W-1:0]               pad_oe,
  output logic [W-1:0]               pad_pu,
  output logic [W-1:0]               pad_pd
);
  logic [W-1:0] in_sync;
  logic [W-1:0] level;

  for (genvar f = 0; f < NFEAT; f++) begin : g_feat
    gpio_sc_reg #(.W(W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (wr_sel[f]),
      .set_mask (wdata[W-1:0]),
      .clr_mask (wdata[2*W-1:W]),
      .q        (feat_q[f])
    );
  end

  gpio_in_sync #(.W(W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (in_sync)
  );

  always_comb begin
    level   = feat_q[F_OUTV] ^ feat_q[F_OINV];
    pad_out = level;
    pad_oe  = feat_q[F_OE] & (~feat_q[F_OD] | ~level);
    pad_pu  = feat_q[F_PU];
    pad_pd  = feat_q[F_PD];
    rb_val  = (in_sync ^ feat_q[F_IINV]) & feat_q[F_IE];
  end

  a_r7_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_q[F_OD] & pad_oe & pad_out) == '0);

  a_r6_oe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~feat_q[F_OE]) == '0);

  a_r9_rb_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_val & ~feat_q[F_IE]) == '0);

  a_r8_pulls_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu == feat_q[F_PU]) && (pad_pd == feat_q[F_PD]));
endmodule

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl
  import gpio_sc_pkg::*;
#(
  parameter int BANK_PINS = 16,
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [2*BANK_PINS-1:0]         wdata,
  output logic [2*BANK_PINS-1:0]         rdata,
  input  logic [BANK_PINS*NUM_BANKS-1:0] pad_in,
  output logic [BANK_PINS*NUM_BANKS-1:0] pad_out,
  output logic [BANK_PINS*NUM_BANKS-1:0] pad_oe,
  output logic [BANK_PINS*NUM_BANKS-1:0] pad_pu,
  output logic [BANK_PINS*NUM_BANKS-1:0] pad_pd
);
  localparam int DW     = 2 * BANK_PINS;
  localparam int BSEL_W = ADDR_W - OFF_W;

  logic                              rst_n_i;
  logic [BSEL_W-1:0]                 bank_idx;
  dec_t                              dec;
  logic [NFEAT-1:0][BANK_PINS-1:0]   bank_fq [NUM_BANKS];
  logic [BANK_PINS-1:0]              bank_rb [NUM_BANKS];
  logic [NFEAT-1:0]                  bank_sel [NUM_BANKS];
  logic [DW-1:0]                     rd_d;
  logic [DW-1:0]                     rdata_q;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign bank_idx = addr[ADDR_W-1:OFF_W];
  assign dec      = decode_off(addr[OFF_W-1:0]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb begin
      bank_sel[b] = '0;
      if (wr_en && (int'(bank_idx) == b) && dec.hit && !dec.is_rb)
        bank_sel[b][dec.feat] = 1'b1;
    end

    gpio_bank #(.W(BANK_PINS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n_i),
      .wr_sel  (bank_sel[b]),
      .wdata   (wdata),
      .pad_in  (pad_in[b*BANK_PINS +: BANK_PINS]),
      .feat_q  (bank_fq[b]),
      .rb_val  (bank_rb[b]),
      .pad_out (pad_out[b*BANK_PINS +: BANK_PINS]),
      .pad_oe  (pad_oe[b*BANK_PINS +: BANK_PINS]),
      .pad_pu  (pad_pu[b*BANK_PINS +: BANK_PINS]),
      .pad_pd  (pad_pd[b*BANK_PINS +: BANK_PINS])
    );

    a_r2_one_feature_per_write: assert property (@(posedge clk) disable iff (!rst_n_i)
      $onehot0(bank_sel[b]));
  end

  always_comb begin
    rd_d = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if ((int'(bank_idx) == b) && dec.hit) begin
        if (dec.is_rb) rd_d = {{BANK_PINS{1'b0}}, bank_rb[b]};
        else           rd_d = {~bank_fq[b][dec.feat], bank_fq[b][dec.feat]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)    rdata_q <= '0;
    else if (rd_en)  rdata_q <= rd_d;
  end

  assign rdata = rdata_q;

  a_r5_read_complement: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_en && dec.hit && !dec.is_rb && (int'(bank_idx) < NUM_BANKS))
      |=> (rdata[DW-1:BANK_PINS] == ~rdata[BANK_PINS-1:0]));

  a_r5_read_holds: assert property (@(posedge clk) disable iff (!rst_n_i)
    !rd_en |=> $stable(rdata));

  a_r10_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_en && !dec.hit) |=> (rdata == '0));

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n_i |-> ((pad_oe == '0) && (pad_pu == '0) && (pad_pd == '0) && (rdata == '0)));
endmodule

// File: tb/gpio_setclr_ctrl_bench.sv
module gpio_setclr_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pad_pu, pad_pd;

  always #2 clk = ~clk;

  gpio_setclr_ctrl u_gpio_setclr_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sq[$];
  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m [2][8];
  logic [31:0] pad_seen = '0;
  logic rd_seen = 1'b0;
  bit done = 0;

  function automatic int feat_of(input logic [6:0] o);
    case (o)
      7'h00: return 0;  7'h04: return 1;  7'h08: return 2;  7'h0C: return 3;
      7'h18: return 4;  7'h1C: return 5;  7'h20: return 6;  7'h24: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    int b = a[7];
    int f = feat_of(a[6:0]);
    logic [15:0] s;
    if (f >= 0) return {~m[b][f], m[b][f]};
    if (a[6:0] == 7'h30) begin
      s = (pad_seen[b*16 +: 16] ^ m[b][7]) & m[b][6];
      return {16'h0, s};
    end
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_pads(input string tag);
    logic [31:0] eo, eoe, epu, epd;
    for (int p = 0; p < 32; p++) begin
      logic v;
      v = m[p/16][0][p%16] ^ m[p/16][3][p%16];
      eo[p]  = v;
      eoe[p] = m[p/16][1][p%16] & (~m[p/16][2][p%16] | ~v);
      epu[p] = m[p/16][4][p%16];
      epd[p] = m[p/16][5][p%16];
    end
    check({tag, " R6 pad_out"}, pad_out, eo);
    check({tag, " R7 pad_oe"}, pad_oe, eoe);
    check({tag, " R8 pad_pu"}, pad_pu, epu);
    check({tag, " R8 pad_pd"}, pad_pd, epd);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    int f;
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    f = feat_of(a[6:0]);
    if (f >= 0) m[a[7]][f] = (m[a[7]][f] | d[15:0]) & ~d[31:16];
    check_pads(tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = exp_read(a);
    it.tag = tag;
    sq.push_back(it);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      item_t it;
      if (sq.size() == 0) check("scoreboard empty", 32'h1, 32'h0);
      else begin
        it = sq.pop_front();
        check(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int f = 0; f < 8; f++) m[b][f] = '0;
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", rdata, 32'h0);
    check_pads("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_pads("R1 after reset");
    for (int b = 0; b < 2; b++)
      for (int f = 0; f < 8; f++) begin
        logic [7:0] offs [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h18, 8'h1C, 8'h20, 8'h24};
        rd(8'(b * 8'h80) | offs[f], "R1 R5 reset register");
      end

    wr(8'h00, 32'h0000_00A5, "R3 set low");
    rd(8'h00, "R3 R5 set low");
    wr(8'h00, 32'h0005_0000, "R4 clear low");
    rd(8'h00, "R4 clear low");
    wr(8'h00, 32'h0082_0083, "R4 both set and clear");
    rd(8'h00, "R4 clear wins");

    wr(8'h04, 32'h0000_00F0, "R6 enable low");
    wr(8'h0C, 32'h0000_0030, "R6 invert low");
    wr(8'h08, 32'h0000_00C0, "R7 open drain low");
    wr(8'h00, 32'h0000_0040, "R7 od level high");
    wr(8'h0C, 32'h0000_0040, "R7 od inverted to zero");
    wr(8'h18, 32'h0000_1234, "R8 pull up");
    wr(8'h1C, 32'h0000_4321, "R8 pull down");

    wr(8'h80, 32'h0000_8001, "R2 high bank level");
    wr(8'h84, 32'h0000_C003, "R2 high bank enable");
    rd(8'h80, "R2 high bank level read");
    rd(8'h84, "R2 high bank enable read");
    rd(8'h04, "R2 low bank unaffected");
    wr(8'h88, 32'h0000_4000, "R7 high bank od");
    wr(8'h88, 32'hFFFF_FFFF, "R4 high bank full clear");
    rd(8'h88, "R4 high bank full clear read");

    wr(8'h30, 32'h0000_FFFF, "R10 write read-back");
    wr(8'h10, 32'h0000_FFFF, "R10 write unmapped");
    wr(8'h02, 32'h0000_FFFF, "R10 write misaligned");
    wr(8'h82, 32'hFFFF_0000, "R10 write misaligned high");
    rd(8'h10, "R10 unmapped reads zero");
    rd(8'h01, "R10 misaligned reads zero");
    rd(8'h00, "R10 level unchanged");
    rd(8'h04, "R10 enable unchanged");

    wr(8'h20, 32'h0000_00FF, "R9 input enable low");
    wr(8'hA0, 32'h0000_FF00, "R9 input enable high");
    wr(8'h24, 32'h0000_000F, "R9 input invert low");
    @(negedge clk);
    pad_in = 32'hA5C3_3C5A;
    rd(8'h30, "R9 read too early sees old");
    pad_seen = pad_in;
    rd(8'h30, "R9 read after two flops");
    rd(8'hB0, "R9 high bank read-back");
    @(negedge clk);
    pad_in = 32'h0F0F_F0F0;
    repeat (3) @(negedge clk);
    pad_seen = pad_in;
    rd(8'h30, "R9 second pattern low");
    rd(8'hB0, "R9 second pattern high");
    wr(8'h20, 32'h00F0_0000, "R9 input disable");
    rd(8'h30, "R9 disabled pins read zero");

    repeat (3) @(negedge clk);
    check("scoreboard drained", 32'(sq.size()), 32'h0);
    done = 1;
    finish_run();
  end
endmodule